// File: doc/BRIEF.md
# DDR SDRAM Self-Refresh Sequencer

This block sits on the controller side of a DDR SDRAM interface. It puts the memory into self-refresh when a power manager asks for it, and brings it back out again. It drives the clock-enable and command pins itself for as long as it holds control. While it is in normal operation, its command pins rest at NOP and the rest of the controller owns the bus.

On an entry request it first makes sure no bank is open. If the open-bank input reports active banks, it issues a precharge-all and waits the row-precharge time. It then issues the self-refresh command with clock enable dropped in the same cycle, and keeps clock enable low for the whole stay.

On an exit request it waits until the clock is reported stable. It then drives one NOP with clock enable still low and raises clock enable. It waits the exit-to-command time and issues one auto-refresh. After the refresh recovery time it hands the bus back. A separate output tells the controller when the longer DLL-lock time has also passed, so that reads are allowed again.

Top module: `ddr_selfref_seq`

## Requirements
- R1: After reset the block is in normal operation: `cke`=1, pins show NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1, `a10`=0), `ready`=1, `read_ok`=1 and `enter_ack`=0.
- R2: An `enter_req` sampled in normal operation with `banks_idle`=1 puts the self-refresh command on the pins in the following cycle: `cs_n`=`ras_n`=`cas_n`=0, `we_n`=1, with `cke`=0 in that same cycle.
- R3: If `banks_idle`=0 when entry is requested, a precharge-all (`cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, `a10`=1) appears in the following cycle. Only NOPs follow it, and the self-refresh command comes exactly `T_RP` cycles after the precharge.
- R4: From the self-refresh command until exit begins, `cke` stays 0 and the pins show deselect (`cs_n`=1). `enter_ack` is high for exactly one cycle, the cycle right after the self-refresh command.
- R5: An exit request that arrives while `clk_stable`=0 is remembered, and `cke` stays low. The exit sequence starts in the cycle after `clk_stable` is seen high, even if `exit_req` was only a one-cycle pulse.
- R6: Exit begins with exactly one cycle of NOP with `cke`=0. `cke` rises in the next cycle, and the pins keep showing NOP.
- R7: The auto-refresh command (`cs_n`=`ras_n`=`cas_n`=0, `we_n`=1, `cke`=1) appears exactly `T_XSNR` cycles after the first cycle with `cke` high, with only NOPs in between.
- R8: `ready` rises exactly `T_RFC` cycles after the auto-refresh cycle. While `ready`=1 the pins show NOP with `cke`=1.
- R9: `read_ok` is high only when `ready` is high and at least `T_XSRD` cycles have passed since the first cycle with `cke` high after the latest exit. A new entry before that point pushes `read_ok` out to the next exit.
- R10: `enter_req` has no effect while the block is in self-refresh or leaving it. `exit_req` has no effect in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Request to enter self-refresh, sampled in normal operation |
| banks_idle | input | 1 | High when all banks are precharged and tRP has already elapsed |
| exit_req | input | 1 | Request to leave self-refresh (a pulse is enough) |
| clk_stable | input | 1 | High when the memory clock is stable |
| enter_ack | output | 1 | One-cycle pulse once self-refresh has been entered |
| ready | output | 1 | Block is in normal operation; the controller may issue non-read commands |
| read_ok | output | 1 | Ready and the DLL lock time has elapsed; reads may be issued |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10; high selects all banks for precharge |

## Verification
The assertions assume that `banks_idle` is truthful: when it is high, every bank is closed and the row-precharge time has already been met, so a direct entry is legal. They also assume that `clk_stable` does not drop once exit has begun, since a clock-stability check is made only on the cycle the exit is started. The bench follows both assumptions. It holds `banks_idle` at a fixed level for each entry, changes inputs only on falling edges, and lowers `clk_stable` only while the block is resident in self-refresh.

// File: rtl/ddr_sr_pkg.sv
package ddr_sr_pkg;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_PRE,
    ST_TRP,
    ST_SRE,
    ST_SELF,
    ST_XNOP,
    ST_XS,
    ST_AREF,
    ST_TRFC
  } sr_state_e;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_DESEL,
    CMD_PRE_ALL,
    CMD_SREF,
    CMD_AREF
  } sr_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sr_pins_t;

  // Pin levels for each command. Self-refresh and auto-refresh share an
  // encoding and differ only in the clock-enable level.
  function automatic sr_pins_t encode_cmd(sr_cmd_e c);
    sr_pins_t p;
    case (c)
      CMD_DESEL:   p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
      CMD_PRE_ALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
      CMD_SREF,
      CMD_AREF:    p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
      default:     p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    endcase
    return p;
  endfunction

  // Timer load for a wait state. gap is the required command-to-command
  // distance in cycles; lead is the number of those cycles spent in the
  // command state that precedes the wait state. A wait state loaded with
  // L lasts L+1 cycles.
  function automatic int unsigned wait_load(int unsigned gap, int unsigned lead);
    return gap - lead - 1;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Counter width for values 0..v, never less than one bit.
  function automatic int unsigned cnt_width(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/ddr_sr_wait_timer.sv
module ddr_sr_wait_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr_sr_pin_drive.sv
module ddr_sr_pin_drive
  import ddr_sr_pkg::*;
(
  input  sr_cmd_e  cmd,
  input  logic     cke_en,
  output logic     cke,
  output sr_pins_t pins
);

  assign pins = encode_cmd(cmd);
  assign cke  = cke_en;

endmodule

// File: rtl/ddr_sr_read_gate.sv
module ddr_sr_read_gate #(
  parameter int unsigned T_XSRD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic ready,
  output logic read_ok
);

  localparam int unsigned GW = ddr_sr_pkg::cnt_width(T_XSRD);
  localparam logic [GW-1:0] LOCK_DONE = GW'(T_XSRD);

  logic [GW-1:0] hi_cnt_q;

  // Counts cycles with cke high since the last low period, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= LOCK_DONE;
    end else if (!cke) begin
      hi_cnt_q <= '0;
    end else if (hi_cnt_q != LOCK_DONE) begin
      hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign read_ok = ready && (hi_cnt_q == LOCK_DONE);

endmodule

// File: rtl/ddr_selfref_seq.sv
module ddr_selfref_seq
  import ddr_sr_pkg::*;
#(
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_XSNR = 10,
  parameter int unsigned T_RFC  = 8,
  parameter int unsigned T_XSRD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic banks_idle,
  input  logic exit_req,
  input  logic clk_stable,
  output logic enter_ack,
  output logic ready,
  output logic read_ok,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic a10
);

  localparam int unsigned LD_RP  = wait_load(T_RP, 1);
  localparam int unsigned LD_XS  = wait_load(T_XSNR, 0);
  localparam int unsigned LD_RFC = wait_load(T_RFC, 1);
  localparam int unsigned CW     = cnt_width(max3(LD_RP, LD_XS, LD_RFC));

  sr_state_e     state_q, state_d;
  logic          exit_pend_q;
  logic          ack_q;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  sr_cmd_e       cmd;
  logic          cke_en;
  sr_pins_t      pins;

  // Named events, exposed for the bound checker.
  logic ev_pre, ev_sre, ev_aref, ev_exit_go, in_self;
  assign ev_pre     = (state_q == ST_PRE);
  assign ev_sre     = (state_q == ST_SRE);
  assign ev_aref    = (state_q == ST_AREF);
  assign in_self    = (state_q == ST_SELF);
  assign ev_exit_go = in_self && (exit_req || exit_pend_q) && clk_stable;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (enter_req) state_d = banks_idle ? ST_SRE : ST_PRE;
      ST_PRE:  state_d = ST_TRP;
      ST_TRP:  if (tmr_done) state_d = ST_SRE;
      ST_SRE:  state_d = ST_SELF;
      ST_SELF: if (ev_exit_go) state_d = ST_XNOP;
      ST_XNOP: state_d = ST_XS;
      ST_XS:   if (tmr_done) state_d = ST_AREF;
      ST_AREF: state_d = ST_TRFC;
      ST_TRFC: if (tmr_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  // The timer is loaded on the edge that enters a wait state.
  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_TRP:  tmr_val = CW'(LD_RP);
      ST_XS:   tmr_val = CW'(LD_XS);
      ST_TRFC: tmr_val = CW'(LD_RFC);
      default: begin
        tmr_val  = '0;
        tmr_load = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      exit_pend_q <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ev_sre;
      if (!in_self || ev_exit_go) begin
        exit_pend_q <= 1'b0;
      end else if (exit_req) begin
        exit_pend_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cke_en = 1'b1;
    case (state_q)
      ST_PRE:  cmd = CMD_PRE_ALL;
      ST_SRE:  begin cmd = CMD_SREF; cke_en = 1'b0; end
      ST_SELF: begin cmd = CMD_DESEL; cke_en = 1'b0; end
      ST_XNOP: begin cmd = CMD_NOP; cke_en = 1'b0; end
      ST_AREF: cmd = CMD_AREF;
      default: cmd = CMD_NOP;
    endcase
  end

  ddr_sr_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  ddr_sr_pin_drive u_pins (
    .cmd    (cmd),
    .cke_en (cke_en),
    .cke    (cke),
    .pins   (pins)
  );

  ddr_sr_read_gate #(.T_XSRD(T_XSRD)) u_rgate (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .ready   (ready),
    .read_ok (read_ok)
  );

  assign ready     = (state_q == ST_RUN);
  assign enter_ack = ack_q;
  assign cs_n      = pins.cs_n;
  assign ras_n     = pins.ras_n;
  assign cas_n     = pins.cas_n;
  assign we_n      = pins.we_n;
  assign a10       = pins.a10;

endmodule

// File: rtl/ddr_selfref_seq_chk.sv
module ddr_selfref_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_stable,
  input logic enter_ack,
  input logic ready,
  input logic read_ok,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10,
  input logic ev_aref,
  input logic ev_pre
);

  logic pin_nop, pin_ref, pin_pre;
  assign pin_nop = !cs_n && ras_n && cas_n && we_n;
  assign pin_ref = !cs_n && !ras_n && !cas_n && we_n;
  assign pin_pre = !cs_n && !ras_n && cas_n && !we_n;

  assert_sref_on_cke_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> pin_ref);

  assert_pre_selects_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |-> (pin_pre && a10 && cke));

  assert_resident_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> (cs_n || pin_nop));

  assert_ack_while_resident_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ack |-> (!cke && cs_n && $past(pin_ref)));

  assert_exit_after_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable, 2));

  assert_nop_before_cke_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ($past(pin_nop) && pin_nop));

  assert_aref_with_cke_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_aref |-> (pin_ref && cke && $past(cke)));

  assert_ready_idle_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cke && pin_nop));

  assert_read_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> ready);

endmodule

bind ddr_selfref_seq ddr_selfref_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_stable (clk_stable),
  .enter_ack  (enter_ack),
  .ready      (ready),
  .read_ok    (read_ok),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .a10        (a10),
  .ev_aref    (ev_aref),
  .ev_pre     (ev_pre)
);

// File: tb/ddr_selfref_seq_bench.sv
`timescale 1ns/100ps
module ddr_selfref_seq_bench;

  localparam int T_RP   = 3;
  localparam int T_XSNR = 10;
  localparam int T_RFC  = 8;
  localparam int T_XSRD = 40;

  localparam int K_PRE = 0, K_SRE = 1, K_ACK = 2, K_XNOP = 3,
                 K_CKEHI = 4, K_AREF = 5, K_READY = 6, K_RDOK = 7;

  typedef struct {
    int kind;
    int at;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_req = 1'b0, banks_idle = 1'b1, exit_req = 1'b0, clk_stable = 1'b1;
  logic enter_ack, ready, read_ok, cke, cs_n, ras_n, cas_n, we_n, a10;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_selfref_seq #(.T_RP(T_RP), .T_XSNR(T_XSNR), .T_RFC(T_RFC), .T_XSRD(T_XSRD))
  u_ddr_selfref_seq (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .banks_idle(banks_idle),
    .exit_req(exit_req), .clk_stable(clk_stable), .enter_ack(enter_ack),
    .ready(ready), .read_ok(read_ok), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10)
  );

  function automatic string req_of(int k);
    case (k)
      K_PRE:   return "R3";
      K_SRE:   return "R2";
      K_ACK:   return "R4";
      K_XNOP:  return "R6";
      K_CKEHI: return "R6";
      K_AREF:  return "R7";
      K_READY: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_val(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: turn pin activity into events and compare against the queue.
  task automatic observe(int kind);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event: actual kind %0d at %0d expected none",
               req_of(kind), kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        errors++;
        $display("FAIL %s event: actual kind %0d at %0d expected kind %0d at %0d",
                 req_of(e.kind), kind, cyc, e.kind, e.at);
      end
    end
  endtask

  logic prev_cke = 1'b1, prev_ready = 1'b1, prev_rdok = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!cs_n && !ras_n && cas_n && !we_n && a10) observe(K_PRE);
      if (!cke && !cs_n && !ras_n && !cas_n && we_n) observe(K_SRE);
      if (enter_ack) observe(K_ACK);
      if (!cke && !cs_n && ras_n && cas_n && we_n) observe(K_XNOP);
      if (cke && !prev_cke) observe(K_CKEHI);
      if (cke && !cs_n && !ras_n && !cas_n && we_n) observe(K_AREF);
      if (ready && !prev_ready) observe(K_READY);
      if (read_ok && !prev_rdok) observe(K_RDOK);
      prev_cke   <= cke;
      prev_ready <= ready;
      prev_rdok  <= read_ok;
    end
  end

  // Driver side: the expected sequence is pushed relative to the request cycle.
  task automatic push(int kind, int at);
    exp_t e;
    e.kind = kind;
    e.at   = at;
    exp_q.push_back(e);
  endtask

  task automatic do_entry(bit idle);
    int r;
    @(negedge clk);
    r = cyc;
    banks_idle = idle;
    enter_req  = 1'b1;
    if (idle) begin
      push(K_SRE, r + 1);                      // R2
      push(K_ACK, r + 2);                      // R4
    end else begin
      push(K_PRE, r + 1);                      // R3
      push(K_SRE, r + 1 + T_RP);
      push(K_ACK, r + 2 + T_RP);
    end
    @(negedge clk);
    enter_req = 1'b0;
  endtask

  // x: cycle in which the exit condition is sampled true.
  task automatic expect_exit(int x, bit rdok);
    int c0, rdy, rd;
    c0  = x + 2;
    rdy = c0 + T_XSNR + T_RFC;
    rd  = (c0 + T_XSRD > rdy) ? c0 + T_XSRD : rdy;
    push(K_XNOP, x + 1);                       // R6
    push(K_CKEHI, c0);
    push(K_AREF, c0 + T_XSNR);                 // R7
    push(K_READY, rdy);                        // R8
    if (rdok) push(K_RDOK, rd);                // R9
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_val("R1", "cke", cke, 1);
    check_val("R1", "cs_n", cs_n, 0);
    check_val("R1", "ras/cas/we", {ras_n, cas_n, we_n}, 3'b111);
    check_val("R1", "a10", a10, 0);
    check_val("R1", "ready", ready, 1);
    check_val("R1", "read_ok", read_ok, 1);
    check_val("R1", "enter_ack", enter_ack, 0);

    // R10: exit request in normal operation does nothing
    exit_req = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
    repeat (10) @(negedge clk);
    check_val("R10", "ready after stray exit", ready, 1);
    check_val("R10", "cke after stray exit", cke, 1);

    // R2/R4: direct entry
    do_entry(1'b1);
    drain();
    check_val("R4", "cke resident", cke, 0);
    check_val("R4", "cs_n resident", cs_n, 1);

    // R10: entry request while resident is ignored
    enter_req = 1'b1;
    banks_idle = 1'b0;
    repeat (4) @(negedge clk);
    enter_req = 1'b0;
    repeat (4) @(negedge clk);
    check_val("R10", "cke after stray entry", cke, 0);
    check_val("R10", "cs_n after stray entry", cs_n, 1);

    // R6/R7/R8/R9: exit with a stable clock
    @(negedge clk);
    exit_req = 1'b1;
    expect_exit(cyc, 1'b1);
    @(negedge clk);
    exit_req = 1'b0;
    drain();
    check_val("R9", "read_ok settled", read_ok, 1);

    // R3: entry with open banks
    do_entry(1'b0);
    drain();

    // R5: exit request held while the clock is unstable
    @(negedge clk);
    clk_stable = 1'b0;
    exit_req   = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
    repeat (20) @(negedge clk);
    check_val("R5", "cke while clock unstable", cke, 0);
    check_val("R5", "cs_n while clock unstable", cs_n, 1);
    clk_stable = 1'b1;
    expect_exit(cyc, 1'b0);
    // R9: re-enter as soon as ready, before DLL lock time
    while (!ready) @(negedge clk);
    check_val("R9", "read_ok before lock time", read_ok, 0);
    do_entry(1'b1);
    drain();
    check_val("R9", "read_ok while resident", read_ok, 0);

    // R9: the lock window restarts on the next exit
    @(negedge clk);
    exit_req = 1'b1;
    expect_exit(cyc, 1'b1);
    @(negedge clk);
    exit_req = 1'b0;
    drain();
    check_val("R8", "ready at end", ready, 1);
    check_val("R9", "read_ok at end", read_ok, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung run expected completion, %0d events pending",
               exp_q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule